// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block looks at one 16-bit instruction word together with the current program counter and the four status flags (carry C, zero Z, sign S, overflow-style N). It decides whether the word is a PC-relative conditional jump and, if so, whether the jump is taken. It then produces the program counter of the next instruction. A word is treated as a jump when its destination-register field selects register 7, which is the program counter. In that case the 4-bit operation field is read as a condition code instead of an arithmetic operation.

The decision logic is purely combinational. A parameter can place one register stage on all outputs so that the block fits a pipeline boundary. A second parameter chooses how the next-PC arithmetic is built: three parallel adders followed by a mux, or one shared adder whose operand is muxed. Both variants give identical results.

Top module: `brres_unit`

## Requirements
- R1: Field layout: bits [15:12] hold the condition code, [11:9] the destination register, [8:6] the direction and [5:0] the unsigned offset. `is_jump_o` is 1 exactly when the destination is 7 and the code is not 15.
- R2: Codes 0..7 test one flag each. The jump is taken for: 0 when C=0, 1 when C=1, 2 when S=0, 3 when S=1, 4 when Z=0, 5 when Z=1, 6 when N=0, 7 when N=1.
- R3: Code 9 is taken when Z=0 and C=1. Code 8 is taken when that condition is false.
- R4: Code 11 is taken when Z=0 and S=0. Code 10 is taken when that condition is false.
- R5: Code 12 is taken when N equals S. Code 13 is taken when N differs from S. Code 14 is always taken.
- R6: Code 15 with destination 7 sets `special_o`=1, `is_jump_o`=0 and `taken_o`=0, and next PC is PC+1. `special_o` and `is_jump_o` are never both 1.
- R7: A destination other than 7 gives `is_jump_o`=0, `special_o`=0 and `taken_o`=0, and next PC is PC+1, for any flags.
- R8: A taken jump with direction field 0 gives next PC = PC + offset, modulo 2^PC_W.
- R9: A taken jump with a nonzero direction field gives next PC = PC - offset, modulo 2^PC_W.
- R10: When no jump is taken, next PC is PC+1 modulo 2^PC_W. This includes the wrap from all ones to zero.
- R11: With `REG_OUT`=1, every output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_i | input | 16 | Instruction word |
| pc_i | input | PC_W | Current program counter |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_n_i | input | 1 | Overflow-style flag compared against S |
| is_jump_o | output | 1 | Word is a relative conditional jump |
| taken_o | output | 1 | Jump condition holds |
| next_pc_o | output | PC_W | Next program counter |
| special_o | output | 1 | Reserved special instruction detected |

## Verification
On every cycle, the assertions check the following:
- a taken jump is always a jump;
- the special and jump indications exclude each other;
- code 14 on a jump is always taken;
- a not-taken outcome always yields PC+1.

Only the bench scenarios can show the full flag truth table of every condition code, the sign and wrap of the offset arithmetic in both directions, and the one-cycle output latency.

// File: rtl/brres_pkg.sv
package brres_pkg;
   localparam int INSN_W   = 16;
   localparam int CODE_W   = 4;
   localparam int REGSEL_W = 3;
   localparam int DIR_W    = 3;
   localparam int OFS_W    = 6;
   localparam logic [REGSEL_W-1:0] PC_REG = 3'd7;

   typedef enum logic [CODE_W-1:0] {
      CC_CCLR, CC_CSET, CC_SCLR, CC_SSET, CC_ZCLR, CC_ZSET, CC_NCLR, CC_NSET,
      CC_NOT_HI, CC_HI, CC_NOT_GT, CC_GT, CC_NS_EQ, CC_NS_NE, CC_ALWAYS, CC_SPECIAL
   } cond_code_e;

   typedef struct packed {
      cond_code_e           code;
      logic [REGSEL_W-1:0]  dest;
      logic [DIR_W-1:0]     dir;
      logic [OFS_W-1:0]     ofs;
   } insn_fields_t;

   typedef struct packed {
      logic c;
      logic z;
      logic s;
      logic n;
   } flags_t;
endpackage

// File: rtl/brres_decode.sv
module brres_decode
   import brres_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSN_W-1:0]  insn_i,
   output insn_fields_t       fields_o,
   output logic               is_jump_o,
   output logic               special_o,
   output logic               backward_o
);
   logic dest_is_pc;

   assign fields_o   = insn_fields_t'(insn_i);
   assign dest_is_pc = (fields_o.dest == PC_REG);
   assign is_jump_o  = dest_is_pc && (fields_o.code != CC_SPECIAL);
   assign special_o  = dest_is_pc && (fields_o.code == CC_SPECIAL);
   assign backward_o = |fields_o.dir;

   // R6
   excl_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_jump_o && special_o));
endmodule

// File: rtl/brres_cond.sv
module brres_cond
   import brres_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  cond_code_e  code_i,
   input  flags_t      flags_i,
   output logic        cond_o
);
   logic hi_cond;
   logic gt_cond;

   assign hi_cond = !flags_i.z && flags_i.c;
   assign gt_cond = !flags_i.z && !flags_i.s;

   always_comb begin
      unique case (code_i)
         CC_CCLR:    cond_o = !flags_i.c;
         CC_CSET:    cond_o =  flags_i.c;
         CC_SCLR:    cond_o = !flags_i.s;
         CC_SSET:    cond_o =  flags_i.s;
         CC_ZCLR:    cond_o = !flags_i.z;
         CC_ZSET:    cond_o =  flags_i.z;
         CC_NCLR:    cond_o = !flags_i.n;
         CC_NSET:    cond_o =  flags_i.n;
         CC_NOT_HI:  cond_o = !hi_cond;
         CC_HI:      cond_o =  hi_cond;
         CC_NOT_GT:  cond_o = !gt_cond;
         CC_GT:      cond_o =  gt_cond;
         CC_NS_EQ:   cond_o = (flags_i.n == flags_i.s);
         CC_NS_NE:   cond_o = (flags_i.n != flags_i.s);
         CC_ALWAYS:  cond_o = 1'b1;
         default:    cond_o = 1'b0;
      endcase
   end

   // R5
   always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == CC_ALWAYS) |-> cond_o);
endmodule

// File: rtl/brres_target.sv
module brres_target
   import brres_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int STYLE = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic             backward_i,
   input  logic             taken_i,
   output logic [PC_W-1:0]  next_pc_o
);
   localparam int EXT_W = PC_W - OFS_W;
   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   logic [PC_W-1:0] ofs_ext;
   assign ofs_ext = {{EXT_W{1'b0}}, ofs_i};

   generate
      if (STYLE == 0) begin : g_parallel
         logic [PC_W-1:0] seq_pc, fwd_pc, bwd_pc;
         assign seq_pc = pc_i + ONE;
         assign fwd_pc = pc_i + ofs_ext;
         assign bwd_pc = pc_i - ofs_ext;
         always_comb begin
            if (!taken_i)        next_pc_o = seq_pc;
            else if (backward_i) next_pc_o = bwd_pc;
            else                 next_pc_o = fwd_pc;
         end
      end else begin : g_shared
         logic [PC_W-1:0] operand;
         logic            carry_in;
         always_comb begin
            if (!taken_i)        operand = ONE;
            else if (backward_i) operand = ~ofs_ext;
            else                 operand = ofs_ext;
         end
         assign carry_in  = taken_i && backward_i;
         assign next_pc_o = pc_i + operand + {{(PC_W-1){1'b0}}, carry_in};
      end
   endgenerate

   // R10
   seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_i |-> (next_pc_o == pc_i + ONE));
endmodule

// File: rtl/brres_unit.sv
module brres_unit
   import brres_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int REG_OUT     = 1,
   parameter int ADDER_STYLE = 0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSN_W-1:0]  insn_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic               flag_c_i,
   input  logic               flag_z_i,
   input  logic               flag_s_i,
   input  logic               flag_n_i,
   output logic               is_jump_o,
   output logic               taken_o,
   output logic [PC_W-1:0]    next_pc_o,
   output logic               special_o
);
   generate
      if (PC_W <= OFS_W) begin : g_bad_pc_w
         $error("brres_unit: PC_W must exceed the offset width");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg_out
         $error("brres_unit: REG_OUT must be 0 or 1");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("brres_unit: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   insn_fields_t    fields;
   flags_t          flags;
   logic            jump_c, special_c, backward_c, cond_c, taken_c;
   logic [PC_W-1:0] next_pc_c;

   assign flags = '{c: flag_c_i, z: flag_z_i, s: flag_s_i, n: flag_n_i};

   brres_decode u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_i     (insn_i),
      .fields_o   (fields),
      .is_jump_o  (jump_c),
      .special_o  (special_c),
      .backward_o (backward_c)
   );

   brres_cond u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .code_i  (fields.code),
      .flags_i (flags),
      .cond_o  (cond_c)
   );

   assign taken_c = jump_c && cond_c;

   brres_target #(.PC_W(PC_W), .STYLE(ADDER_STYLE)) u_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .pc_i       (pc_i),
      .ofs_i      (fields.ofs),
      .backward_i (backward_c),
      .taken_i    (taken_c),
      .next_pc_o  (next_pc_o_c_wire)
   );

   logic [PC_W-1:0] next_pc_o_c_wire;
   assign next_pc_c = next_pc_o_c_wire;

   generate
      if (REG_OUT == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               is_jump_o <= 1'b0;
               taken_o   <= 1'b0;
               next_pc_o <= '0;
               special_o <= 1'b0;
            end else begin
               is_jump_o <= jump_c;
               taken_o   <= taken_c;
               next_pc_o <= next_pc_c;
               special_o <= special_c;
            end
         end
      end else begin : g_comb
         assign is_jump_o = jump_c;
         assign taken_o   = taken_c;
         assign next_pc_o = next_pc_c;
         assign special_o = special_c;
      end
   endgenerate

   // R1
   taken_is_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> is_jump_o);

   // R6
   special_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      special_o |-> !taken_o);
endmodule

// File: tb/brres_unit_bench.sv
module brres_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W       = 16;
   localparam int REG_OUT    = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [15:0]     insn_i = '0;
   logic [PC_W-1:0] pc_i = '0;
   logic            flag_c_i = 0, flag_z_i = 0, flag_s_i = 0, flag_n_i = 0;
   logic            is_jump_o, taken_o, special_o;
   logic [PC_W-1:0] next_pc_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brres_unit #(.PC_W(PC_W), .REG_OUT(REG_OUT)) u_brres_unit (
      .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .pc_i(pc_i),
      .flag_c_i(flag_c_i), .flag_z_i(flag_z_i), .flag_s_i(flag_s_i), .flag_n_i(flag_n_i),
      .is_jump_o(is_jump_o), .taken_o(taken_o), .next_pc_o(next_pc_o), .special_o(special_o)
   );

   function automatic bit ref_cond(input int code, input bit c, z, s, n);
      case (code)
         0: return !c;         1: return c;
         2: return !s;         3: return s;
         4: return !z;         5: return z;
         6: return !n;         7: return n;
         8: return !(!z && c); 9: return !z && c;
         10: return !(!z && !s); 11: return !z && !s;
         12: return n == s;    13: return n != s;
         14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [3:0] code, input logic [2:0] dest, input logic [2:0] dir,
                        input logic [5:0] ofs, input logic [PC_W-1:0] pc, input logic [3:0] fl);
      @(negedge clk);
      insn_i = {code, dest, dir, ofs};
      pc_i = pc;
      {flag_c_i, flag_z_i, flag_s_i, flag_n_i} = fl;
      if (REG_OUT == 1) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      if (REG_OUT == 1) begin
         insn_i = {4'd14, 3'd7, 3'd0, 6'd5};
         pc_i = 16'h1234;
         #1;
         check("R11 reset is_jump", is_jump_o, 0);
         check("R11 reset taken", taken_o, 0);
         check("R11 reset next_pc", next_pc_o, 0);
         check("R11 reset special", special_o, 0);
      end
   endtask

   task automatic t_sweep;
      for (int code = 0; code < 15; code++) begin
         for (int fl = 0; fl < 16; fl++) begin
            bit c, z, s, n, exp_t;
            logic [PC_W-1:0] exp_pc;
            {c, z, s, n} = fl[3:0];
            exp_t = ref_cond(code, c, z, s, n);
            exp_pc = exp_t ? 16'h0100 + 16'd9 : 16'h0101;
            apply(code[3:0], 3'd7, 3'd0, 6'd9, 16'h0100, fl[3:0]);
            if (code < 8)       check("R2 single-flag taken", taken_o, exp_t);
            else if (code < 10) check("R3 Z/C pair taken", taken_o, exp_t);
            else if (code < 12) check("R4 Z/S pair taken", taken_o, exp_t);
            else                check("R5 N/S or always taken", taken_o, exp_t);
            check("R1 jump detect", is_jump_o, 1);
            check("R8 next pc in sweep", next_pc_o, exp_pc);
         end
      end
   endtask

   task automatic t_special;
      for (int fl = 0; fl < 16; fl += 5) begin
         apply(4'd15, 3'd7, 3'd0, 6'd3, 16'h2000, fl[3:0]);
         check("R6 special flag", special_o, 1);
         check("R6 not a jump", is_jump_o, 0);
         check("R6 not taken", taken_o, 0);
         check("R6 next pc", next_pc_o, 16'h2001);
      end
   endtask

   task automatic t_non_jump;
      for (int d = 0; d < 7; d++) begin
         apply(4'd14, d[2:0], 3'd0, 6'd20, 16'h0400, 4'hF);
         check("R7 no jump", is_jump_o, 0);
         check("R7 no special", special_o, 0);
         check("R7 not taken", taken_o, 0);
         check("R7 next pc", next_pc_o, 16'h0401);
      end
      apply(4'd15, 3'd2, 3'd1, 6'd20, 16'h0400, 4'h0);
      check("R7 code 15 other dest special", special_o, 0);
      check("R1 code 15 other dest jump", is_jump_o, 0);
   endtask

   task automatic t_forward;
      apply(4'd14, 3'd7, 3'd0, 6'd63, 16'h1000, 4'h0);
      check("R8 forward max", next_pc_o, 16'h103F);
      apply(4'd14, 3'd7, 3'd0, 6'd0, 16'h1000, 4'h0);
      check("R8 forward zero", next_pc_o, 16'h1000);
      apply(4'd14, 3'd7, 3'd0, 6'd16, 16'hFFF8, 4'h0);
      check("R8 forward wrap", next_pc_o, 16'h0008);
   endtask

   task automatic t_backward;
      for (int dir = 1; dir < 8; dir++) begin
         apply(4'd14, 3'd7, dir[2:0], 6'd33, 16'h0500, 4'h0);
         check("R9 backward", next_pc_o, 16'h04DF);
      end
      apply(4'd14, 3'd7, 3'd4, 6'd5, 16'h0002, 4'h0);
      check("R9 backward wrap", next_pc_o, 16'hFFFD);
      apply(4'd4, 3'd7, 3'd4, 6'd5, 16'h0002, 4'b0100);
      check("R10 backward not taken", next_pc_o, 16'h0003);
   endtask

   task automatic t_seq_wrap;
      apply(4'd5, 3'd7, 3'd0, 6'd7, 16'hFFFF, 4'h0);
      check("R10 untaken wrap taken", taken_o, 0);
      check("R10 untaken wrap", next_pc_o, 16'h0000);
   endtask

   task automatic t_latency;
      if (REG_OUT == 1) begin
         @(negedge clk);
         insn_i = {4'd14, 3'd7, 3'd0, 6'd2};
         pc_i = 16'h0700;
         @(posedge clk);
         #1;
         insn_i = {4'd15, 3'd7, 3'd0, 6'd2};
         #1;
         check("R11 holds prior edge taken", taken_o, 1);
         check("R11 holds prior edge pc", next_pc_o, 16'h0702);
         @(posedge clk);
         #1;
         check("R11 next edge special", special_o, 1);
      end
   endtask

   initial begin
      t_reset;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_sweep;
      t_special;
      t_non_jump;
      t_forward;
      t_backward;
      t_seq_wrap;
      t_latency;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog R11: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule